// File: doc/BRIEF.md
# Chip-Enable Framed Serial Command Receiver

This block is a serial slave that takes display and control commands from a host over three wires, a chip enable, a serial clock and a data line. It answers on a fourth, open-drain line. A frame starts with an 8-bit device address, which is clocked in while chip enable is low. Chip enable then rises. If the address matched, the payload bits that follow while chip enable is high go into a shadow register. When chip enable falls, the shadow is copied into the active display and control registers, but only if exactly the expected number of payload bits arrived. A one-cycle load strobe tells the display logic that new contents are valid.

The serial lines are oversampled in the block clock domain. The host may leave the serial clock resting low or resting high between transfers, and both behave the same. While a matched frame is open, the open-drain line returns a snapshot of the key inputs, one bit per serial clock. When chip enable is low the line is always released.

Top module: `cce_rx`

## Requirements
- R1: After rst_ni is released, all display and control outputs are 0, load_o is 0 and sdo_pull_o is 0.
- R2: The device address is the last 8 bits sampled on rising serial clock edges while chip enable is low. The first of those bits is address bit 0. The frame is selected only if at least 8 such bits arrived and the byte equals DEV_ADDR (0x42 by default). Earlier extra bits are ignored.
- R3: Payload bit k (counting from 0) goes to disp_o[k] for k < DISP_BITS. The next nine bits go, in this order, to sleep_o[0], sleep_o[1], scan_sel_o[0], scan_sel_o[1], port_sel_o[0], port_sel_o[1], port_sel_o[2], seg_off_o and bias_o.
- R4: A selected frame with exactly DISP_BITS+9 payload bits updates all outputs when chip enable falls. In that same cycle load_o is 1, and only for one cycle.
- R5: A selected frame with fewer or more payload bits than DISP_BITS+9 changes no output and gives no load_o pulse.
- R6: A frame whose address does not match changes no output, gives no load_o pulse and keeps sdo_pull_o at 0.
- R7: A frame is accepted the same way whether the serial clock rests high or low between bits and around chip enable changes.
- R8: sdo_pull_o is 0 whenever chip enable is low. In a selected frame, before the (k+1)th payload rising edge, sdo_pull_o is 1 exactly when key bit k of the snapshot taken at chip enable rise is 0 (the pulled-up line then reads the key bit). For k >= KEY_BITS the line is released.
- R9: While dev_rst_ni is low, frames are still received and committed, and every key bit reads as 0 (sdo_pull_o is 1 for k < KEY_BITS).
- R10: Outputs hold their value between load_o pulses.
- R11: A chip enable high phase with no preceding address bits is not selected, even right after a selected frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dev_rst_ni | input | 1 | Device hold, low forces key data to 0 |
| ce_i | input | 1 | Chip enable: low for address, high for payload |
| sclk_i | input | 1 | Serial clock, data sampled on rising edge |
| sdi_i | input | 1 | Serial data in |
| key_i | input | KEY_BITS | Key state to return to the host |
| sdo_pull_o | output | 1 | 1 pulls the open-drain return line low |
| disp_o | output | DISP_BITS | Active display data |
| sleep_o | output | 2 | Sleep control field |
| scan_sel_o | output | 2 | Scan/segment select field |
| port_sel_o | output | 3 | Port select field |
| seg_off_o | output | 1 | All-segments-off control |
| bias_o | output | 1 | Bias scheme select |
| load_o | output | 1 | One-cycle strobe on commit |

## Verification
The bench builds the block with DISP_BITS=12 and KEY_BITS=5, so a full frame is 21 payload bits. The short frame lets every frame read past the last key bit, which checks the released tail of the return line. Frames one bit short and two bits long are also cheap to run. It keeps DEV_ADDR at 0x42 and sends a near miss, 0x43, plus an address preceded by two garbage bits. Frames are sent with the serial clock resting both low and high.

// File: rtl/cce_pkg.sv
package cce_pkg;
  localparam int CTRL_W = 9;

  // field order from bit 0 upward follows payload arrival order
  typedef struct packed {
    logic       bias;
    logic       seg_off;
    logic [2:0] port_sel;
    logic [1:0] scan_sel;
    logic [1:0] sleep;
  } ctrl_t;
endpackage

// File: rtl/cce_sync.sv
module cce_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/cce_frame.sv
module cce_frame #(
  parameter int          TOTAL    = 229,
  parameter logic [7:0]  DEV_ADDR = 8'h42,
  localparam int         CW       = $clog2(TOTAL + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_ph_i,
  input  logic             ce_rise_i,
  input  logic             ce_fall_i,
  input  logic             bit_rise_i,
  input  logic             din_i,
  output logic             sel_o,
  output logic             commit_o,
  output logic [TOTAL-1:0] shadow_o
);
  localparam logic [CW-1:0] FULL = CW'(TOTAL);
  localparam logic [CW-1:0] OVER = CW'(TOTAL + 1);

  logic [7:0]       addr_q;
  logic [3:0]       acnt_q;
  logic [CW-1:0]    bcnt_q;
  logic             sel_q;
  logic [TOTAL-1:0] shadow_q;

  assign commit_o = ce_fall_i && sel_q && (bcnt_q == FULL);
  assign sel_o    = sel_q;
  assign shadow_o = shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      acnt_q <= '0;
    end else if (ce_rise_i) begin
      addr_q <= '0;
      acnt_q <= '0;
    end else if (bit_rise_i && !ce_ph_i) begin
      addr_q <= {din_i, addr_q[7:1]};
      if (acnt_q != 4'd8) acnt_q <= acnt_q + 4'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      bcnt_q <= '0;
    end else if (ce_rise_i) begin
      sel_q  <= (acnt_q == 4'd8) && (addr_q == DEV_ADDR);
      bcnt_q <= '0;
    end else if (ce_fall_i) begin
      sel_q  <= 1'b0;
    end else if (bit_rise_i && ce_ph_i && sel_q && bcnt_q != OVER) begin
      bcnt_q <= bcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= '0;
    else if (bit_rise_i && ce_ph_i && sel_q && bcnt_q < FULL)
      shadow_q[bcnt_q] <= din_i;
  end
endmodule

// File: rtl/cce_regs.sv
module cce_regs
  import cce_pkg::*;
#(
  parameter int  DISP_BITS = 220,
  localparam int TOTAL     = DISP_BITS + CTRL_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 commit_i,
  input  logic [TOTAL-1:0]     shadow_i,
  output logic [DISP_BITS-1:0] disp_o,
  output ctrl_t                ctrl_o,
  output logic                 load_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_o <= '0;
      ctrl_o <= '0;
      load_o <= 1'b0;
    end else begin
      load_o <= commit_i;
      if (commit_i) begin
        disp_o <= shadow_i[DISP_BITS-1:0];
        ctrl_o <= ctrl_t'(shadow_i[TOTAL-1 -: CTRL_W]);
      end
    end
  end
endmodule

// File: rtl/cce_keyout.sv
module cce_keyout #(
  parameter int  KEY_BITS = 30,
  localparam int IW       = $clog2(KEY_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dev_rst_ni,
  input  logic                ce_rise_i,
  input  logic                ce_ph_i,
  input  logic                bit_rise_i,
  input  logic                sel_i,
  input  logic [KEY_BITS-1:0] key_i,
  output logic                pull_o
);
  logic [KEY_BITS:0] snap_q;  // top bit is a released guard past the last key
  logic [IW-1:0]     idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '1;
      idx_q  <= '0;
    end else if (ce_rise_i) begin
      snap_q <= {1'b1, (dev_rst_ni ? key_i : '0)};
      idx_q  <= '0;
    end else if (bit_rise_i && ce_ph_i && idx_q != IW'(KEY_BITS)) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign pull_o = sel_i && !snap_q[idx_q];
endmodule

// File: rtl/cce_rx.sv
module cce_rx
  import cce_pkg::*;
#(
  parameter int         DISP_BITS   = 220,
  parameter int         KEY_BITS    = 30,
  parameter logic [7:0] DEV_ADDR    = 8'h42,
  parameter int         SYNC_STAGES = 2,
  localparam int        TOTAL       = DISP_BITS + CTRL_W,
  localparam int        NLINES      = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dev_rst_ni,
  input  logic                 ce_i,
  input  logic                 sclk_i,
  input  logic                 sdi_i,
  input  logic [KEY_BITS-1:0]  key_i,
  output logic                 sdo_pull_o,
  output logic [DISP_BITS-1:0] disp_o,
  output logic [1:0]           sleep_o,
  output logic [1:0]           scan_sel_o,
  output logic [2:0]           port_sel_o,
  output logic                 seg_off_o,
  output logic                 bias_o,
  output logic                 load_o
);
  logic [NLINES-1:0] raw, lvl;
  logic              ce_d, sclk_d;
  logic              ce_rise, ce_fall, bit_rise;
  logic              sel, commit;
  logic [TOTAL-1:0]  shadow;
  ctrl_t             ctrl;

  assign raw = {sdi_i, sclk_i, ce_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    cce_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[g]),
      .q_o   (lvl[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_d   <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      ce_d   <= lvl[0];
      sclk_d <= lvl[1];
    end
  end

  // ce_d is the phase level; it moves on the same edge that acts on a ce change
  assign ce_rise  =  lvl[0] && !ce_d;
  assign ce_fall  = !lvl[0] &&  ce_d;
  assign bit_rise =  lvl[1] && !sclk_d;

  cce_frame #(.TOTAL(TOTAL), .DEV_ADDR(DEV_ADDR)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_ph_i   (ce_d),
    .ce_rise_i (ce_rise),
    .ce_fall_i (ce_fall),
    .bit_rise_i(bit_rise),
    .din_i     (lvl[2]),
    .sel_o     (sel),
    .commit_o  (commit),
    .shadow_o  (shadow)
  );

  cce_regs #(.DISP_BITS(DISP_BITS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(commit),
    .shadow_i(shadow),
    .disp_o  (disp_o),
    .ctrl_o  (ctrl),
    .load_o  (load_o)
  );

  cce_keyout #(.KEY_BITS(KEY_BITS)) u_keyout (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dev_rst_ni(dev_rst_ni),
    .ce_rise_i (ce_rise),
    .ce_ph_i   (ce_d),
    .bit_rise_i(bit_rise),
    .sel_i     (sel),
    .key_i     (key_i),
    .pull_o    (sdo_pull_o)
  );

  assign sleep_o    = ctrl.sleep;
  assign scan_sel_o = ctrl.scan_sel;
  assign port_sel_o = ctrl.port_sel;
  assign seg_off_o  = ctrl.seg_off;
  assign bias_o     = ctrl.bias;
endmodule

// File: rtl/cce_rx_chk.sv
module cce_rx_chk #(
  parameter int DISP_BITS = 220
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ce_d,
  input logic                 sel,
  input logic                 load_o,
  input logic                 sdo_pull_o,
  input logic [DISP_BITS-1:0] disp_o,
  input logic [1:0]           sleep_o,
  input logic [1:0]           scan_sel_o,
  input logic [2:0]           port_sel_o,
  input logic                 seg_off_o,
  input logic                 bias_o
);
  AST_LOAD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o); // R4

  AST_LOAD_AFTER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> ($past(sel) && !ce_d)); // R4

  AST_HOLD_BETWEEN_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |-> ($stable(disp_o) && $stable({sleep_o, scan_sel_o, port_sel_o, seg_off_o, bias_o}))); // R10

  AST_DO_RELEASED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_d |-> !sdo_pull_o); // R8

  AST_DO_ONLY_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_pull_o |-> sel); // R6
endmodule

bind cce_rx cce_rx_chk #(.DISP_BITS(DISP_BITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_d      (ce_d),
  .sel       (sel),
  .load_o    (load_o),
  .sdo_pull_o(sdo_pull_o),
  .disp_o    (disp_o),
  .sleep_o   (sleep_o),
  .scan_sel_o(scan_sel_o),
  .port_sel_o(port_sel_o),
  .seg_off_o (seg_off_o),
  .bias_o    (bias_o)
);

// File: tb/cce_rx_bench.sv
module cce_rx_bench;
  localparam int DISP  = 12;
  localparam int KEYS  = 5;
  localparam int TOTAL = DISP + 9;
  localparam int HALF  = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dev_rst_ni = 1'b1;
  logic ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [KEYS-1:0] key = '0;
  logic sdo_pull, load;
  logic [DISP-1:0] disp;
  logic [1:0] sleep, scan_sel;
  logic [2:0] port_sel;
  logic seg_off, bias;

  int errors = 0, checks = 0, loads_seen = 0, loads_exp = 0;
  bit done = 1'b0;
  logic [TOTAL-1:0] exp_q[$];
  logic [TOTAL-1:0] model = '0;

  always #5 clk = ~clk;

  cce_rx #(.DISP_BITS(DISP), .KEY_BITS(KEYS)) u_cce_rx (
    .clk_i(clk), .rst_ni(rst_ni), .dev_rst_ni(dev_rst_ni),
    .ce_i(ce), .sclk_i(sclk), .sdi_i(sdi), .key_i(key),
    .sdo_pull_o(sdo_pull), .disp_o(disp), .sleep_o(sleep),
    .scan_sel_o(scan_sel), .port_sel_o(port_sel),
    .seg_off_o(seg_off), .bias_o(bias), .load_o(load)
  );

  function automatic logic [TOTAL-1:0] outs();
    return {bias, seg_off, port_sel, scan_sel, sleep, disp};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected contents on every load strobe
  always @(negedge clk) begin
    if (rst_ni && load) begin
      loads_seen++;
      if (exp_q.size() == 0) check("R4 unexpected load", 32'(outs()), 32'(model));
      else check("R3 load contents", 32'(outs()), 32'(exp_q.pop_front()));
    end
  end

  // one serial bit; optional check of the return line before the rising edge
  task automatic send_bit(input logic b, input bit idle_hi, input bit chk, input logic exp_pull, input string req);
    if (idle_hi) sclk = 1'b0;
    sdi = b;
    wait_n(HALF);
    if (chk) check(req, 32'(sdo_pull), 32'(exp_pull));
    sclk = 1'b1;
    wait_n(HALF);
    if (!idle_hi) sclk = 1'b0;
  endtask

  task automatic send_frame(input logic [15:0] abits, input int na,
                            input logic [31:0] pay, input int np,
                            input bit idle_hi, input bit exp_sel,
                            input logic [KEYS-1:0] kexp, input string req);
    bit commit;
    commit = exp_sel && (np == TOTAL);
    sclk = idle_hi;
    wait_n(HALF);
    for (int i = 0; i < na; i++) send_bit(abits[i], idle_hi, 1'b1, 1'b0, "R8 idle release");
    ce = 1'b1;
    wait_n(6);
    for (int k = 0; k < np; k++)
      send_bit(pay[k], idle_hi, 1'b1, exp_sel && (k < KEYS) && !kexp[k], req);
    if (commit) begin
      exp_q.push_back(pay[TOTAL-1:0]);
      model = pay[TOTAL-1:0];
      loads_exp++;
    end
    ce = 1'b0;
    wait_n(12);
    check({req, " load count"}, 32'(loads_seen), 32'(loads_exp));
    check({req, " R10 held outputs"}, 32'(outs()), 32'(model));
    check({req, " R8 released"}, 32'(sdo_pull), 32'(0));
  endtask

  localparam logic [15:0] ADDR_OK  = 16'h0042;
  localparam logic [15:0] ADDR_BAD = 16'h0043;

  initial begin
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(2);
    check("R1 reset outputs", 32'(outs()), 32'(0));
    check("R1 reset load", 32'(load), 32'(0));
    check("R1 reset sdo", 32'(sdo_pull), 32'(0));

    key = 5'b10110;
    send_frame(ADDR_OK, 8, 32'h0015_A5C3, TOTAL, 1'b0, 1'b1, key, "R2 R3 R4 R8 idle low");
    key = 5'b01001;
    send_frame(ADDR_OK, 8, 32'h001A_3C96, TOTAL, 1'b1, 1'b1, key, "R7 idle high");
    send_frame(ADDR_OK, 8, 32'h000F_0F0F, TOTAL - 1, 1'b0, 1'b1, key, "R5 short frame");
    send_frame(ADDR_OK, 8, 32'h007F_FFFF, TOTAL + 2, 1'b1, 1'b1, key, "R5 long frame");
    send_frame(ADDR_BAD, 8, 32'h0012_3456, TOTAL, 1'b0, 1'b0, key, "R6 wrong address");
    // two garbage bits ahead of the address; the last eight decide
    send_frame((ADDR_OK << 2) | 16'h3, 10, 32'h0005_5AA5, TOTAL, 1'b0, 1'b1, key, "R2 prefix bits");
    dev_rst_ni = 1'b0;
    key = 5'b11111;
    send_frame(ADDR_OK, 8, 32'h001C_C33C, TOTAL, 1'b1, 1'b1, 5'b00000, "R9 held device");
    dev_rst_ni = 1'b1;
    send_frame(16'h0, 0, 32'h0001_FFFF, TOTAL, 1'b0, 1'b0, key, "R11 no address");
    send_frame(ADDR_OK, 8, 32'h0000_0001, TOTAL, 1'b0, 1'b1, key, "R3 single bit");

    check("R4 queue drained", 32'(exp_q.size()), 32'(0));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1-chain actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule